// File: doc/BRIEF.md
# Addressed Multidrop Serial Receiver

This block receives asynchronous serial frames on one line and recognises, in hardware, the address frames meant for this node on a shared multidrop link. A frame has a low start bit, eight data bits sent least significant first, a ninth bit that marks address frames, and a high stop bit. The line is sampled on a strobe that runs at sixteen times the bit rate. The receiver locks onto a falling edge and rechecks the start bit in its middle. Each later bit is sampled at its own centre.

When address filtering is off, every frame with a good stop bit is handed over. When filtering is on, only frames with the ninth bit set are candidates, and such a frame is handed over only if its byte matches this node. A node match is a compare against a slave address that uses a per-bit mask, where masked-off positions are ignored. A group match requires ones in every position where the address OR the mask is one. The byte and the ninth bit are held until the next accepted frame replaces them. A done flag and a sticky framing-error flag are each cleared by their own pulse input.

Top module: `mpAddrRx`

## Requirements
- R1: After reset, rxData is 0, rxBit9 is 0, rxDone is 0 and frameErr is 0.
- R2: A frame starts on a 1-to-0 change of the line. It is a low start bit, then DATA_W data bits least significant first, a ninth bit and a stop bit. Each bit is sampled once, at its centre, on the oversampling strobe (OVS strobes per bit). With a high stop bit and acceptance granted, rxData takes the data bits (first bit in bit 0), rxBit9 takes the ninth bit and rxDone goes to 1.
- R3: If the line is high again when the start bit is rechecked at its centre, the receiver returns to idle. It sets no flag and leaves rxData unchanged, and the frame that follows is received normally.
- R4: With mpEnable = 0, every frame with a high stop bit is accepted, whatever its ninth bit.
- R5: With mpEnable = 1, a frame whose ninth bit is 0 is discarded. rxDone stays 0 and rxData and rxBit9 keep their values.
- R6: With mpEnable = 1 and ninth bit 1, a frame is accepted on a node match, where (byte XOR slaveAddr) AND addrMask is zero. For address 8'b1100_0000 and mask 8'b1111_1101, the bytes 8'b1100_0000 and 8'b1100_0010 are accepted and 8'b1100_0001 is rejected.
- R7: With mpEnable = 1 and ninth bit 1, a frame is also accepted on a group match, where the byte has a 1 in every position in which (slaveAddr OR addrMask) is 1. For the address and mask of R6, the byte 8'hFF is accepted.
- R8: A low stop bit sets frameErr and the frame is not delivered. frameErr stays 1 until a clearFrameErr pulse.
- R9: A clearDone pulse clears rxDone and leaves rxData and rxBit9 unchanged.
- R10: After a frame ends, a new frame starts only on a fresh 1-to-0 change. A line held low after a low stop bit does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleTick | input | 1 | Oversampling strobe, OVS per bit time |
| rxLine | input | 1 | Serial receive line, idle high |
| slaveAddr | input | DATA_W | Node address |
| addrMask | input | DATA_W | Per-bit address compare enable |
| mpEnable | input | 1 | Address filtering on |
| clearDone | input | 1 | Pulse that clears rxDone |
| clearFrameErr | input | 1 | Pulse that clears frameErr |
| rxData | output | DATA_W | Last accepted byte |
| rxBit9 | output | 1 | Ninth bit of the last accepted frame |
| rxDone | output | 1 | An accepted frame is waiting |
| frameErr | output | 1 | Sticky framing error |

## Verification
The bench builds the block with DATA_W = 8 and OVS = 16, and pulses the sampling strobe on every second clock. A bit therefore lasts 32 clocks. At this size a whole frame takes a few hundred cycles, so many random frames fit in one run. Random address, mask and byte values are drawn near the address or with forced group bits, so that node matches, group matches and rejects all occur. The eight-bit width also lets the bench reproduce the fixed mask example exactly.

// File: rtl/mpRxPkg.sv
package mpRxPkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_NINTH = 3'd3,
    ST_STOP  = 3'd4
  } rxState_t;

  typedef struct packed {
    logic shiftIn;   // data bit centre: shift the line in
    logic capNinth;  // ninth bit centre: capture the line
    logic stopGood;  // stop bit centre, line high
    logic stopBad;   // stop bit centre, line low
  } rxStrobe_t;
endpackage

// File: rtl/mpAddrMatch.sv
module mpAddrMatch #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] rxByte,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic [DATA_W-1:0] addrMask,
  output logic              nodeHit,
  output logic              groupHit
);
  logic [DATA_W-1:0] nodeOk;
  logic [DATA_W-1:0] groupOk;

  for (genvar i = 0; i < DATA_W; i++) begin : gBit
    // a bit passes when ignored by the mask or equal to the address
    assign nodeOk[i]  = !addrMask[i] || (rxByte[i] == slaveAddr[i]);
    // group pattern: required ones where address or mask is one
    assign groupOk[i] = !(slaveAddr[i] || addrMask[i]) || rxByte[i];
  end

  assign nodeHit  = &nodeOk;
  assign groupHit = &groupOk;
endmodule

// File: rtl/mpRxCtrl.sv
module mpRxCtrl
  import mpRxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      lineS,
  input  logic      startEdge,
  output rxStrobe_t stb
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OVS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic             atCentre;

  assign atCentre = sampleTick && (tickCnt == FULL_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitIdx  <= '0;
    end else if (sampleTick) begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (startEdge) state <= ST_START;
        end
        ST_START: begin
          if (tickCnt == MID_CNT) begin
            tickCnt <= '0;
            bitIdx  <= '0;
            state   <= lineS ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (tickCnt == FULL_CNT) begin
            tickCnt <= '0;
            if (bitIdx == LAST_IDX) state <= ST_NINTH;
            else bitIdx <= bitIdx + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_NINTH: begin
          if (tickCnt == FULL_CNT) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (tickCnt == FULL_CNT) begin
            tickCnt <= '0;
            state   <= ST_IDLE;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.shiftIn  = (state == ST_DATA)  && atCentre;
    stb.capNinth = (state == ST_NINTH) && atCentre;
    stb.stopGood = (state == ST_STOP)  && atCentre && lineS;
    stb.stopBad  = (state == ST_STOP)  && atCentre && !lineS;
  end

  // R2: at most one strobe per cycle toward the datapath
  a_r2_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.shiftIn, stb.capNinth, stb.stopGood, stb.stopBad}));

  // R3: a high line at the start-bit recheck returns to idle
  a_r3_false_start_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && sampleTick && tickCnt == MID_CNT && lineS) |=> (state == ST_IDLE));

  // R10: idle leaves only on a detected falling edge
  a_r10_idle_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(sampleTick && startEdge)) |=> (state == ST_IDLE));
endmodule

// File: rtl/mpRxDatapath.sv
module mpRxDatapath
  import mpRxPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              rxLine,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic [DATA_W-1:0] addrMask,
  input  logic              mpEnable,
  input  logic              clearDone,
  input  logic              clearFrameErr,
  input  rxStrobe_t         stb,
  output logic              lineS,
  output logic              startEdge,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxDone,
  output logic              frameErr
);
  logic              syncA;
  logic              prevS;
  logic [DATA_W-1:0] shiftReg;
  logic              ninthReg;
  logic              nodeHit;
  logic              groupHit;
  logic              acceptOk;
  logic              deliver;

  // two-stage synchroniser, reset to the idle level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      lineS <= 1'b1;
    end else begin
      syncA <= rxLine;
      lineS <= syncA;
    end
  end

  // line level seen on the previous strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           prevS <= 1'b1;
    else if (sampleTick) prevS <= lineS;
  end

  assign startEdge = prevS && !lineS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      ninthReg <= 1'b0;
    end else begin
      if (stb.shiftIn)  shiftReg <= {lineS, shiftReg[DATA_W-1:1]};
      if (stb.capNinth) ninthReg <= lineS;
    end
  end

  mpAddrMatch #(.DATA_W(DATA_W)) uMatch (
    .rxByte   (shiftReg),
    .slaveAddr(slaveAddr),
    .addrMask (addrMask),
    .nodeHit  (nodeHit),
    .groupHit (groupHit)
  );

  assign acceptOk = !mpEnable || (ninthReg && (nodeHit || groupHit));
  assign deliver  = stb.stopGood && acceptOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxBit9 <= 1'b0;
      rxDone <= 1'b0;
    end else if (deliver) begin
      rxData <= shiftReg;
      rxBit9 <= ninthReg;
      rxDone <= 1'b1;
    end else if (clearDone) begin
      rxDone <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              frameErr <= 1'b0;
    else if (stb.stopBad)   frameErr <= 1'b1;
    else if (clearFrameErr) frameErr <= 1'b0;
  end

  // R5: under filtering a newly raised done flag carries a ninth bit of one
  a_r5_filter_ninth: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxDone) && $past(mpEnable)) |-> rxBit9);

  // R8: a bad stop bit leaves the delivered byte untouched
  a_r8_bad_stop_keeps_data: assert property (@(posedge clk) disable iff (!rstN)
    stb.stopBad |=> $stable(rxData));

  // R8: framing error holds until cleared
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !clearFrameErr) |=> frameErr);

  // R9: clear without a competing delivery drops the flag and keeps the byte
  a_r9_clear_done: assert property (@(posedge clk) disable iff (!rstN)
    (clearDone && !stb.stopGood) |=> (!rxDone && $stable(rxData)));
endmodule

// File: rtl/mpAddrRx.sv
module mpAddrRx
  import mpRxPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              rxLine,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic [DATA_W-1:0] addrMask,
  input  logic              mpEnable,
  input  logic              clearDone,
  input  logic              clearFrameErr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxDone,
  output logic              frameErr
);
  rxStrobe_t stb;
  logic      lineS;
  logic      startEdge;

  mpRxCtrl #(.DATA_W(DATA_W), .OVS(OVS)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleTick(sampleTick),
    .lineS     (lineS),
    .startEdge (startEdge),
    .stb       (stb)
  );

  mpRxDatapath #(.DATA_W(DATA_W)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .sampleTick   (sampleTick),
    .rxLine       (rxLine),
    .slaveAddr    (slaveAddr),
    .addrMask     (addrMask),
    .mpEnable     (mpEnable),
    .clearDone    (clearDone),
    .clearFrameErr(clearFrameErr),
    .stb          (stb),
    .lineS        (lineS),
    .startEdge    (startEdge),
    .rxData       (rxData),
    .rxBit9       (rxBit9),
    .rxDone       (rxDone),
    .frameErr     (frameErr)
  );
endmodule

// File: tb/mpAddrRx_test.sv
module mpAddrRx_test;
  localparam int DATA_W  = 8;
  localparam int OVS     = 16;
  localparam int BIT_CLK = OVS * 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              sampleTick = 1'b0;
  logic              rxLine = 1'b1;
  logic [DATA_W-1:0] slaveAddr = '0;
  logic [DATA_W-1:0] addrMask = '0;
  logic              mpEnable = 1'b0;
  logic              clearDone = 1'b0;
  logic              clearFrameErr = 1'b0;
  logic [DATA_W-1:0] rxData;
  logic              rxBit9;
  logic              rxDone;
  logic              frameErr;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] expData = '0;
  logic              expBit9 = 1'b0;

  always #2 clk = ~clk;

  mpAddrRx #(.DATA_W(DATA_W), .OVS(OVS)) uut (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .slaveAddr(slaveAddr), .addrMask(addrMask), .mpEnable(mpEnable),
    .clearDone(clearDone), .clearFrameErr(clearFrameErr),
    .rxData(rxData), .rxBit9(rxBit9), .rxDone(rxDone), .frameErr(frameErr)
  );

  initial forever begin
    @(negedge clk);
    sampleTick = ~sampleTick;
  end

  function automatic logic expAccept(logic [DATA_W-1:0] d, logic b9, logic mp,
                                     logic [DATA_W-1:0] a, logic [DATA_W-1:0] m);
    logic node, grp;
    if (!mp) return 1'b1;
    if (!b9) return 1'b0;
    node = (((d ^ a) & m) == '0);
    grp  = (((~d) & (a | m)) == '0);
    return node || grp;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic holdLine(logic v, int clocks);
    rxLine = v;
    repeat (clocks) @(negedge clk);
  endtask

  task automatic sendFrame(logic [DATA_W-1:0] d, logic b9, logic stopV);
    holdLine(1'b0, BIT_CLK);
    for (int i = 0; i < DATA_W; i++) holdLine(d[i], BIT_CLK);
    holdLine(b9, BIT_CLK);
    holdLine(stopV, BIT_CLK);
  endtask

  task automatic pulseClearDone();
    clearDone = 1'b1;
    @(negedge clk);
    clearDone = 1'b0;
    @(negedge clk);
  endtask

  task automatic runFrame(string req, logic [DATA_W-1:0] d, logic b9);
    logic acc;
    pulseClearDone();
    sendFrame(d, b9, 1'b1);
    holdLine(1'b1, 2 * BIT_CLK);
    acc = expAccept(d, b9, mpEnable, slaveAddr, addrMask);
    if (acc) begin
      expData = d;
      expBit9 = b9;
    end
    chk({req, " done"}, 32'(rxDone), 32'(acc));
    chk({req, " data"}, 32'(rxData), 32'(expData));
    chk({req, " bit9"}, 32'(rxBit9), 32'(expBit9));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 rxData", 32'(rxData), 0);
    chk("R1 rxBit9", 32'(rxBit9), 0);
    chk("R1 rxDone", 32'(rxDone), 0);
    chk("R1 frameErr", 32'(frameErr), 0);
    rstN = 1'b1;
    holdLine(1'b1, 2 * BIT_CLK);

    // R2 / R4: plain reception, filter off, both ninth-bit values
    mpEnable = 1'b0;
    runFrame("R2 plain A5", 8'hA5, 1'b0);
    runFrame("R4 ninth set", 8'h3C, 1'b1);
    runFrame("R4 ninth clear", 8'h81, 1'b0);

    // R9: clear keeps the byte
    pulseClearDone();
    chk("R9 done cleared", 32'(rxDone), 0);
    chk("R9 data kept", 32'(rxData), 32'(expData));

    // R3: short low glitch, then a normal frame
    holdLine(1'b0, 8);
    holdLine(1'b1, 3 * BIT_CLK);
    chk("R3 no done", 32'(rxDone), 0);
    chk("R3 no err", 32'(frameErr), 0);
    chk("R3 data kept", 32'(rxData), 32'(expData));
    runFrame("R3 after glitch", 8'h5A, 1'b1);

    // R5 / R6 / R7: fixed mask example
    mpEnable  = 1'b1;
    slaveAddr = 8'b1100_0000;
    addrMask  = 8'b1111_1101;
    runFrame("R5 ninth clear discarded", 8'b1100_0000, 1'b0);
    runFrame("R6 exact", 8'b1100_0000, 1'b1);
    runFrame("R6 dont care bit", 8'b1100_0010, 1'b1);
    runFrame("R6 reject", 8'b1100_0001, 1'b1);
    runFrame("R7 group FF", 8'hFF, 1'b1);
    runFrame("R7 group FD", 8'hFD, 1'b1);

    // R8 / R10: bad stop, line held low afterwards
    pulseClearDone();
    sendFrame(8'h77, 1'b1, 1'b0);
    holdLine(1'b0, 3 * BIT_CLK);
    chk("R8 err set", 32'(frameErr), 1);
    chk("R8 no done", 32'(rxDone), 0);
    chk("R8 data kept", 32'(rxData), 32'(expData));
    holdLine(1'b1, 2 * BIT_CLK);
    chk("R10 no frame from held low", 32'(rxDone), 0);
    chk("R8 err sticky", 32'(frameErr), 1);
    clearFrameErr = 1'b1;
    @(negedge clk);
    clearFrameErr = 1'b0;
    @(negedge clk);
    chk("R8 err cleared", 32'(frameErr), 0);
    runFrame("R10 after error", 8'hC0, 1'b1);

    // random mix
    for (int n = 0; n < 48; n++) begin
      logic [DATA_W-1:0] d;
      logic b9;
      slaveAddr = DATA_W'($urandom);
      addrMask  = DATA_W'($urandom);
      mpEnable  = 1'($urandom);
      b9        = 1'($urandom);
      case ($urandom % 4)
        0: d = slaveAddr;
        1: d = slaveAddr ^ (DATA_W'(1) << ($urandom % DATA_W));
        2: d = (slaveAddr | addrMask) | DATA_W'($urandom);
        default: d = DATA_W'($urandom);
      endcase
      runFrame(mpEnable ? (b9 ? "R6 R7 random" : "R5 random") : "R4 random", d, b9);
    end
    chk("R8 no err in random", 32'(frameErr), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule